// File: doc/BRIEF.md
# Event-Selectable Performance Counter

This block counts occurrences of one hardware event chosen by software out of a vector of single-cycle event pulses. A control register chooses which event feeds the counter, whether counting happens while the core runs in user mode, in kernel mode or in both, and whether counting is enabled at all. The counter is a 32-bit register that software can read and write.

The most significant bit of the counter drives an interrupt line. Software normally preloads the counter with a negative offset, so the interrupt fires after a chosen number of events. The handler clears the interrupt by writing a value whose top bit is zero. Event sources and interrupt routing belong to the surrounding design.

Both registers sit behind one write/read port. The port has a one-bit register select: 0 picks the control register and 1 picks the count register. Writes take effect on the clock edge, and the read data is a combinational view of the selected register.

Top module: `perfcnt_top`

## Requirements
- R1: After synchronous reset, the count register and the control register both read 0, and `irq_o` is low.
- R2: A write with `reg_sel_i`=0 stores the control fields: bits 4:0 are the event select, bit 5 enables counting in user mode, bit 6 enables counting in kernel mode and bit 7 is the global enable. Bits 31:8 read back as zero.
- R3: A write with `reg_sel_i`=1 stores any 32-bit value into the count register. The value reads back from the next cycle.
- R4: When counting is allowed and the selected event input is high at a clock edge, the count increases by exactly one at that edge.
- R5: Only the event whose index equals the select field is counted. Pulses on every other event input leave the count unchanged.
- R6: Select values 22 to 31 choose no event, and the count holds whatever the event inputs do.
- R7: `priv_kernel_i`=1 marks kernel mode and 0 marks user mode. An event is counted only if the enable bit for the current mode (bit 6 for kernel, bit 5 for user) is set.
- R8: While the global enable bit 7 is clear, the count never increments.
- R9: A write to the count register in the same cycle as a countable event stores the written value, and the event is dropped.
- R10: The count wraps from 0xFFFFFFFF to 0 on an event. The interrupt then goes low.
- R11: `irq_o` is high exactly while count bit 31 is set. It stays high until software writes a count with bit 31 clear, or until the count wraps.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| evt_i | input | 22 | Event pulse vector, one bit per event type |
| priv_kernel_i | input | 1 | Current privilege: 1 kernel, 0 user |
| reg_wr_i | input | 1 | Register write strobe |
| reg_sel_i | input | 1 | Register select: 0 control, 1 count |
| reg_wdata_i | input | 32 | Write data |
| reg_rdata_o | output | 32 | Read data of the selected register |
| irq_o | output | 1 | Counter interrupt, equal to count bit 31 |

## Verification
Any wrong internal state shows up at the ports one cycle after the stimulus. A faulty select decode, mode gate or enable gate changes the count that reads back right after an event pulse. A wrong write priority or a wrong wrap shows up as a wrong count value on the next read. A bad interrupt path appears as `irq_o` disagreeing with the top bit of the count in the same cycle. The bench sweeps every select value against every event index and every combination of mode and enable bits, so a single bad decode entry shows up after one event pulse.

// File: rtl/perfcnt_pkg.sv
package perfcnt_pkg;

    parameter int CNT_W   = 32;
    parameter int NUM_EVT = 22;
    parameter int SEL_W   = 5;
    parameter int REG_W   = 32;

    localparam int CTRL_USED = SEL_W + 3;

    typedef enum logic {
        PRIV_USER   = 1'b0,
        PRIV_KERNEL = 1'b1
    } priv_e;

    typedef enum logic {
        RSEL_CTRL  = 1'b0,
        RSEL_COUNT = 1'b1
    } rsel_e;

    typedef struct packed {
        logic             glob_en;
        logic             kern_en;
        logic             user_en;
        logic [SEL_W-1:0] evt_sel;
    } ctrl_t;

    function automatic ctrl_t unpack_ctrl(input logic [REG_W-1:0] w);
        ctrl_t c;
        c.evt_sel = w[SEL_W-1:0];
        c.user_en = w[SEL_W];
        c.kern_en = w[SEL_W+1];
        c.glob_en = w[SEL_W+2];
        return c;
    endfunction

    function automatic logic [REG_W-1:0] pack_ctrl(input ctrl_t c);
        logic [REG_W-1:0] w;
        w = '0;
        w[CTRL_USED-1:0] = c;
        return w;
    endfunction

    function automatic logic mode_allowed(input ctrl_t c, input priv_e p);
        return (p == PRIV_KERNEL) ? c.kern_en : c.user_en;
    endfunction

endpackage

// File: rtl/perfcnt_ctrl_reg.sv
module perfcnt_ctrl_reg
    import perfcnt_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             wr_i,
    input  logic [REG_W-1:0] wdata_i,
    output ctrl_t            ctrl_o
);

    ctrl_t ctrl_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl_q <= '0;
        end else if (wr_i) begin
            ctrl_q <= unpack_ctrl(wdata_i);
        end
    end

    assign ctrl_o = ctrl_q;

    assert_ctrl_store_R2: assert property (@(posedge clk) disable iff (rst)
        wr_i |=> (ctrl_q.evt_sel == $past(wdata_i[SEL_W-1:0]) &&
                  ctrl_q.glob_en == $past(wdata_i[SEL_W+2])));

    assert_ctrl_hold_R2: assert property (@(posedge clk) disable iff (rst)
        !wr_i |=> $stable(ctrl_q));

endmodule

// File: rtl/perfcnt_evt_sel.sv
module perfcnt_evt_sel
    import perfcnt_pkg::*;
(
    input  logic [NUM_EVT-1:0] evt_i,
    input  priv_e              priv_i,
    input  ctrl_t              ctrl_i,
    output logic               inc_o
);

    logic [NUM_EVT-1:0] hit;

    generate
        for (genvar i = 0; i < NUM_EVT; i++) begin : g_dec
            assign hit[i] = evt_i[i] && (ctrl_i.evt_sel == SEL_W'(i));
        end
    endgenerate

    logic any_hit;
    assign any_hit = |hit;
    assign inc_o   = any_hit && ctrl_i.glob_en && mode_allowed(ctrl_i, priv_i);

    always_comb begin
        assert_onehot_hit_R5: assert ($onehot0(hit));
    end

endmodule

// File: rtl/perfcnt_counter.sv
module perfcnt_counter
    import perfcnt_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             wr_i,
    input  logic [CNT_W-1:0] wdata_i,
    input  logic             inc_i,
    output logic [CNT_W-1:0] cnt_o
);

    logic [CNT_W-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= '0;
        end else if (wr_i) begin
            cnt_q <= wdata_i;
        end else if (inc_i) begin
            cnt_q <= cnt_q + CNT_W'(1);
        end
    end

    assign cnt_o = cnt_q;

    assert_write_wins_R9: assert property (@(posedge clk) disable iff (rst)
        wr_i |=> cnt_q == $past(wdata_i));

    assert_step_one_R4: assert property (@(posedge clk) disable iff (rst)
        (!wr_i && inc_i) |=> cnt_q == $past(cnt_q) + CNT_W'(1));

    assert_idle_hold_R5: assert property (@(posedge clk) disable iff (rst)
        (!wr_i && !inc_i) |=> $stable(cnt_q));

    assert_wrap_zero_R10: assert property (@(posedge clk) disable iff (rst)
        (!wr_i && inc_i && (&cnt_q)) |=> cnt_q == '0);

endmodule

// File: rtl/perfcnt_top.sv
module perfcnt_top
    import perfcnt_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  logic [NUM_EVT-1:0] evt_i,
    input  logic               priv_kernel_i,
    input  logic               reg_wr_i,
    input  logic               reg_sel_i,
    input  logic [REG_W-1:0]   reg_wdata_i,
    output logic [REG_W-1:0]   reg_rdata_o,
    output logic               irq_o
);

    ctrl_t            ctrl;
    logic             inc;
    logic [CNT_W-1:0] cnt;
    logic             wr_ctrl;
    logic             wr_cnt;
    priv_e            priv;

    assign wr_ctrl = reg_wr_i && (rsel_e'(reg_sel_i) == RSEL_CTRL);
    assign wr_cnt  = reg_wr_i && (rsel_e'(reg_sel_i) == RSEL_COUNT);
    assign priv    = priv_e'(priv_kernel_i);

    perfcnt_ctrl_reg u_ctrl (
        .clk     (clk),
        .rst     (rst),
        .wr_i    (wr_ctrl),
        .wdata_i (reg_wdata_i),
        .ctrl_o  (ctrl)
    );

    perfcnt_evt_sel u_sel (
        .evt_i  (evt_i),
        .priv_i (priv),
        .ctrl_i (ctrl),
        .inc_o  (inc)
    );

    perfcnt_counter u_cnt (
        .clk     (clk),
        .rst     (rst),
        .wr_i    (wr_cnt),
        .wdata_i (reg_wdata_i[CNT_W-1:0]),
        .inc_i   (inc),
        .cnt_o   (cnt)
    );

    always_comb begin
        if (rsel_e'(reg_sel_i) == RSEL_COUNT) begin
            reg_rdata_o = REG_W'(cnt);
        end else begin
            reg_rdata_o = pack_ctrl(ctrl);
        end
    end

    assign irq_o = cnt[CNT_W-1];

    assert_irq_sticky_R11: assert property (@(posedge clk) disable iff (rst)
        (irq_o && !wr_cnt && !(&cnt)) |=> irq_o);

    assert_glob_off_R8: assert property (@(posedge clk) disable iff (rst)
        (!ctrl.glob_en && !wr_cnt) |=> $stable(cnt));

    assert_reserved_sel_R6: assert property (@(posedge clk) disable iff (rst)
        (ctrl.evt_sel >= SEL_W'(NUM_EVT) && !wr_cnt) |=> $stable(cnt));

    assert_mode_gate_R7: assert property (@(posedge clk) disable iff (rst)
        (!mode_allowed(ctrl, priv) && !wr_cnt) |=> $stable(cnt));

endmodule

// File: tb/perfcnt_top_test.sv
module perfcnt_top_test;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [21:0] evt_i = '0;
    logic        priv_kernel_i = 1'b0;
    logic        reg_wr_i = 1'b0;
    logic        reg_sel_i = 1'b0;
    logic [31:0] reg_wdata_i = '0;
    logic [31:0] reg_rdata_o;
    logic        irq_o;

    int checks = 0;
    int errors = 0;
    logic [31:0] exp_cnt;

    always #4 clk = ~clk;

    perfcnt_top uut (
        .clk           (clk),
        .rst           (rst),
        .evt_i         (evt_i),
        .priv_kernel_i (priv_kernel_i),
        .reg_wr_i      (reg_wr_i),
        .reg_sel_i     (reg_sel_i),
        .reg_wdata_i   (reg_wdata_i),
        .reg_rdata_o   (reg_rdata_o),
        .irq_o         (irq_o)
    );

    task automatic step();
        @(posedge clk);
        #2;
    endtask

    task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s: got %h expected %h", req, got, exp);
        end
    endtask

    task automatic wr_reg(input logic sel, input logic [31:0] d);
        reg_wr_i = 1'b1; reg_sel_i = sel; reg_wdata_i = d;
        step();
        reg_wr_i = 1'b0;
    endtask

    function automatic logic [31:0] mk_ctrl(input int sel, input bit u, input bit k, input bit g);
        return {24'h0, g, k, u, 5'(sel)};
    endfunction

    task automatic read_cnt(output logic [31:0] v);
        reg_sel_i = 1'b1;
        #1 v = reg_rdata_o;
    endtask

    task automatic pulse(input int e);
        evt_i = 22'(1) << e;
        step();
        evt_i = '0;
    endtask

    initial begin
        #1500000;
        errors++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        logic [31:0] v;
        step(); step();
        rst = 1'b0;
        step();
        // R1 reset state
        read_cnt(v);   chk("R1 count", v, 32'h0);
        reg_sel_i = 1'b0; #1 chk("R1 ctrl", reg_rdata_o, 32'h0);
        chk("R1 irq", {31'h0, irq_o}, 32'h0);

        // R2 control readback, upper bits zero
        wr_reg(1'b0, 32'hFFFF_FFAB);
        reg_sel_i = 1'b0; #1 chk("R2 ctrl readback", reg_rdata_o, 32'h0000_00AB);
        wr_reg(1'b0, 32'h1234_5654);
        reg_sel_i = 1'b0; #1 chk("R2 ctrl readback", reg_rdata_o, 32'h0000_0054);

        // R3 count writes
        wr_reg(1'b1, 32'hDEAD_BEEF);
        read_cnt(v); chk("R3 count readback", v, 32'hDEAD_BEEF);
        wr_reg(1'b1, 32'h0000_0000);
        read_cnt(v); chk("R3 count readback", v, 32'h0);

        // R4 R5 R6 sweep select against event index, kernel mode, all enabled
        priv_kernel_i = 1'b1;
        exp_cnt = 0;
        for (int s = 0; s < 32; s++) begin
            wr_reg(1'b0, mk_ctrl(s, 1, 1, 1));
            for (int e = 0; e < 22; e++) begin
                pulse(e);
                if (e == s) exp_cnt = exp_cnt + 1;
                read_cnt(v);
                if (s >= 22) chk("R6 reserved select", v, exp_cnt);
                else if (e == s) chk("R4 selected increment", v, exp_cnt);
                else chk("R5 other event ignored", v, exp_cnt);
            end
            // R6 all events at once
            evt_i = '1; step(); evt_i = '0;
            if (s < 22) exp_cnt = exp_cnt + 1;
            read_cnt(v); chk(s >= 22 ? "R6 all events reserved" : "R4 all events", v, exp_cnt);
        end

        // R7 R8 mode and enable gating
        for (int g = 0; g < 2; g++)
            for (int u = 0; u < 2; u++)
                for (int k = 0; k < 2; k++)
                    for (int m = 0; m < 2; m++) begin
                        wr_reg(1'b0, mk_ctrl(7, bit'(u), bit'(k), bit'(g)));
                        priv_kernel_i = m[0];
                        pulse(7);
                        if (g == 1 && ((m == 1) ? k == 1 : u == 1)) exp_cnt = exp_cnt + 1;
                        read_cnt(v);
                        chk(g == 0 ? "R8 global enable" : "R7 mode gating", v, exp_cnt);
                    end

        // R9 write wins over event
        wr_reg(1'b0, mk_ctrl(3, 1, 1, 1));
        priv_kernel_i = 1'b0;
        evt_i = 22'(1) << 3;
        wr_reg(1'b1, 32'h0000_0100);
        evt_i = '0;
        read_cnt(v); chk("R9 write priority", v, 32'h0000_0100);
        pulse(3);
        read_cnt(v); chk("R9 counting resumes", v, 32'h0000_0101);

        // R11 interrupt set on crossing into bit 31
        wr_reg(1'b1, 32'h7FFF_FFFF);
        chk("R11 irq low below", {31'h0, irq_o}, 32'h0);
        pulse(3);
        read_cnt(v); chk("R11 count", v, 32'h8000_0000);
        chk("R11 irq raised", {31'h0, irq_o}, 32'h1);
        wr_reg(1'b0, mk_ctrl(3, 1, 1, 0));
        pulse(3); step();
        chk("R11 irq held", {31'h0, irq_o}, 32'h1);
        wr_reg(1'b1, 32'h4000_0000);
        chk("R11 irq cleared by write", {31'h0, irq_o}, 32'h0);
        wr_reg(1'b1, 32'hC000_0000);
        chk("R11 irq set by write", {31'h0, irq_o}, 32'h1);

        // R10 wrap
        wr_reg(1'b0, mk_ctrl(3, 1, 1, 1));
        wr_reg(1'b1, 32'hFFFF_FFFF);
        chk("R10 irq before wrap", {31'h0, irq_o}, 32'h1);
        pulse(3);
        read_cnt(v); chk("R10 wrap to zero", v, 32'h0);
        chk("R10 irq after wrap", {31'h0, irq_o}, 32'h0);

        // R1 reset again clears everything
        wr_reg(1'b1, 32'h8000_0005);
        rst = 1'b1; step(); rst = 1'b0;
        read_cnt(v); chk("R1 count after reset", v, 32'h0);
        chk("R1 irq after reset", {31'h0, irq_o}, 32'h0);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule